// File: doc/BRIEF.md
# Set/Clear Control Register with Sticky Sense Flags

This block is the control and status word of a JTAG probe, reached over a small register bus. Firmware changes control bits through two write addresses. A one written at the set address turns the matching bit on. A one written at the clear address turns it off. Zero bits leave the register alone, so no read-modify-write is ever needed. The control bits drive the system reset, the test reset, the target power switch, two indicator LEDs and the selection between adaptive return-clock mode and fixed divided-clock mode.

Three asynchronous sense inputs each pass through a synchroniser and then latch a sticky status flag. The inputs report a system reset seen asserted, a target power dropout and an adaptive-clock timeout. The system-reset and power-dropout flags are re-armed by writing their bit to the set address. That write clears the latch and samples the input again, so the next read shows whether the condition is still present. The timeout flag is cleared by writing its bit to the clear address. A read at either address returns the live control bits merged with the flags.

Top module: `sense_ctrl_reg`

## Requirements
- R1: A write to the set address (default 0x10) sets every implemented control bit whose data bit is one and leaves all other bits unchanged. The implemented control bits are 0, 1, 3, 4, 5 and 8. A write of all ones gives a control value of 0x13B.
- R2: A write to the clear address (default 0x14) clears every control bit whose data bit is one and leaves all other bits unchanged.
- R3: Each control bit drives one output. Bit 0 drives sys_rst_o and bit 1 drives test_rst_o; a one asserts the reset. Bit 3 drives pwr_off_o, where a one means target power is off. Bits 4 and 5 drive led_o[0] and led_o[1]. Bit 8 drives rclk_mode_o, where a one selects adaptive clock mode.
- R4: After reset, all control bits and all flags are zero. Power is therefore on and both LEDs are off, and a read returns 0.
- R5: A read sets bus_rvalid one cycle later. At the set or clear address, bus_rdata returns the control bits ORed with the flags: bit 6 is the system-reset flag, bit 7 the power-dropout flag and bit 10 the timeout flag. All other bits read 0, and a read at any other address returns 0.
- R6: When sense_sysrst_i is high, flag bit 6 is set within three clock edges. The flag stays set after the input falls.
- R7: Writing 0x40 to the set address clears flag bit 6 and samples it again. The flag reads 0 afterwards only if the synchronised input is low.
- R8: Flag bit 7 latches sense_pwr_drop_i, including a pulse two cycles long. Writing 0x80 to the set address clears and re-samples it. Writing 0x80 to the clear address does not change it.
- R9: Flag bit 10 latches sense_rclk_to_i. Writing 0x400 to the clear address clears it. Writing 0x400 to the set address does not change it.
- R10: Writes to any address other than the set and clear addresses change no control bit and no flag. Writes to flag bit positions never change a control output.
- R11: If a synchronised event and a clear reach a flag in the same cycle, the event wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data is valid this cycle |
| sense_sysrst_i | input | 1 | Asynchronous sense: system reset asserted |
| sense_pwr_drop_i | input | 1 | Asynchronous sense: target power dropped |
| sense_rclk_to_i | input | 1 | Asynchronous sense: adaptive clock timed out |
| sys_rst_o | output | 1 | System reset request |
| test_rst_o | output | 1 | Test logic reset request |
| pwr_off_o | output | 1 | Target power switched off |
| led_o | output | 2 | Indicator LEDs |
| rclk_mode_o | output | 1 | Adaptive return-clock mode selected |

## Verification
A control output changes at the same clock edge that samples the write. The bench therefore checks the outputs at the falling edge right after the write strobe. Read data arrives one edge after the read strobe. The driver queues the expected word when it issues the read, and the monitor compares that word at the next falling edge where bus_rvalid is high. A sense input needs three edges to reach its flag, two for the synchroniser and one for the sticky flop. Before reading a flag, the bench holds or releases the input for at least four cycles. It keeps the input high during a re-arm write to show that the event wins.

// File: rtl/scr_pkg.sv
package scr_pkg;
   // Bit positions of control bits and flags in the register word.
   localparam int B_SYSRST  = 0;
   localparam int B_TESTRST = 1;
   localparam int B_PWROFF  = 3;
   localparam int B_LED0    = 4;
   localparam int B_LED1    = 5;
   localparam int B_SEEN    = 6;
   localparam int B_DROP    = 7;
   localparam int B_RCLK    = 8;
   localparam int B_TMO     = 10;
   localparam int STATUS_MSB = 10;

   localparam logic [31:0] CTRL_MASK32 =
      (32'd1 << B_SYSRST) | (32'd1 << B_TESTRST) | (32'd1 << B_PWROFF) |
      (32'd1 << B_LED0)   | (32'd1 << B_LED1)    | (32'd1 << B_RCLK);

   localparam int NUM_FLAGS = 3;

   typedef enum logic {REARM_ON_SET, CLEAR_ON_CLR} flag_clear_e;

   function automatic int flag_pos(int idx);
      case (idx)
         0:       return B_SEEN;
         1:       return B_DROP;
         default: return B_TMO;
      endcase
   endfunction

   function automatic flag_clear_e flag_mode(int idx);
      return (idx == 2) ? CLEAR_ON_CLR : REARM_ON_SET;
   endfunction
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= async_i;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/scr_sticky.sv
module scr_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic clear_i,
   output logic flag_o
);
   // An event in the same cycle as a clear keeps the flag set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= event_i | (flag_o & ~clear_i);
   end
endmodule

// File: rtl/scr_ctrl_bits.sv
module scr_ctrl_bits #(
   parameter int              DATA_W = 32,
   parameter logic [DATA_W-1:0] MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic [DATA_W-1:0] clr_vec,
   output logic [DATA_W-1:0] ctrl_q
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (MASK[b]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ctrl_q[b] <= 1'b0;
            else if (set_vec[b]) ctrl_q[b] <= 1'b1;
            else if (clr_vec[b]) ctrl_q[b] <= 1'b0;
         end
      end else begin : g_tie
         assign ctrl_q[b] = 1'b0;
      end
   end

   logic unused_bits;
   assign unused_bits = ^((set_vec | clr_vec) & ~MASK);
endmodule

// File: rtl/sense_ctrl_reg.sv
module sense_ctrl_reg #(
   parameter int              DATA_W      = 32,
   parameter int              ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] SET_OFS   = 8'h10,
   parameter logic [ADDR_W-1:0] CLR_OFS   = 8'h14,
   parameter int              SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   input  logic              sense_sysrst_i,
   input  logic              sense_pwr_drop_i,
   input  logic              sense_rclk_to_i,
   output logic              sys_rst_o,
   output logic              test_rst_o,
   output logic              pwr_off_o,
   output logic [1:0]        led_o,
   output logic              rclk_mode_o
);
   import scr_pkg::*;

   localparam logic [DATA_W-1:0] CMASK = CTRL_MASK32[DATA_W-1:0];
   localparam int NF = NUM_FLAGS;

   if (DATA_W <= STATUS_MSB || DATA_W > 32) begin : g_bad_width
      $error("DATA_W must lie between %0d and 32", STATUS_MSB + 1);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SET_OFS == CLR_OFS) begin : g_bad_ofs
      $error("set and clear offsets must differ");
   end

   logic              hit_set, hit_clr, hit_rd;
   logic [DATA_W-1:0] set_vec, clr_vec, ctrl_q, status;
   logic [NF-1:0]     sense_raw, sense_sync, flag_q;

   assign hit_set = bus_wr_en && (bus_addr == SET_OFS);
   assign hit_clr = bus_wr_en && (bus_addr == CLR_OFS);
   assign hit_rd  = (bus_addr == SET_OFS) || (bus_addr == CLR_OFS);
   assign set_vec = hit_set ? bus_wdata : '0;
   assign clr_vec = hit_clr ? bus_wdata : '0;

   scr_ctrl_bits #(.DATA_W(DATA_W), .MASK(CMASK)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .ctrl_q  (ctrl_q)
   );

   assign sense_raw = {sense_rclk_to_i, sense_pwr_drop_i, sense_sysrst_i};

   scr_sync #(.WIDTH(NF), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sense_raw),
      .sync_o  (sense_sync)
   );

   for (genvar gi = 0; gi < NF; gi++) begin : g_flag
      localparam int POS = flag_pos(gi);
      logic clr;
      if (flag_mode(gi) == REARM_ON_SET) begin : g_rearm
         assign clr = set_vec[POS];
      end else begin : g_w1c
         assign clr = clr_vec[POS];
      end
      scr_sticky u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .event_i (sense_sync[gi]),
         .clear_i (clr),
         .flag_o  (flag_q[gi])
      );
   end

   always_comb begin
      status = ctrl_q;
      for (int i = 0; i < NF; i++) status[flag_pos(i)] = flag_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_rd_en;
         bus_rdata  <= (bus_rd_en && hit_rd) ? status : '0;
      end
   end

   assign sys_rst_o   = ctrl_q[B_SYSRST];
   assign test_rst_o  = ctrl_q[B_TESTRST];
   assign pwr_off_o   = ctrl_q[B_PWROFF];
   assign led_o       = {ctrl_q[B_LED1], ctrl_q[B_LED0]};
   assign rclk_mode_o = ctrl_q[B_RCLK];
endmodule

// File: rtl/sense_ctrl_reg_chk.sv
module sense_ctrl_reg_chk #(
   parameter int              DATA_W = 32,
   parameter int              ADDR_W = 8,
   parameter logic [ADDR_W-1:0] SET_OFS = 8'h10,
   parameter logic [ADDR_W-1:0] CLR_OFS = 8'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_en,
   input logic              bus_rd_en,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rvalid,
   input logic              sys_rst_o,
   input logic              test_rst_o,
   input logic              pwr_off_o,
   input logic [1:0]        led_o,
   input logic              rclk_mode_o,
   input logic [2:0]        sense_sync,
   input logic [2:0]        flag_q
);
   logic wr_set, wr_clr;
   assign wr_set = bus_wr_en && (bus_addr == SET_OFS);
   assign wr_clr = bus_wr_en && (bus_addr == CLR_OFS);

   assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set && bus_wdata[0] |=> sys_rst_o);

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr && bus_wdata[1] |=> !test_rst_o);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_set && !wr_clr |=> $stable({sys_rst_o, test_rst_o, pwr_off_o, led_o, rclk_mode_o}));

   assert_rvalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en |=> bus_rvalid);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[0] && !(wr_set && bus_wdata[6]) |=> flag_q[0]);

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[1] && !(wr_set && bus_wdata[7]) |=> flag_q[1]);

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[2] && !(wr_clr && bus_wdata[10]) |=> flag_q[2]);

   assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sense_sync[0] |=> flag_q[0]);

   assert_event_wins_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sense_sync[1] |=> flag_q[1]);

   assert_event_wins_tmo_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sense_sync[2] |=> flag_q[2]);
endmodule

bind sense_ctrl_reg sense_ctrl_reg_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
   .sys_rst_o(sys_rst_o), .test_rst_o(test_rst_o), .pwr_off_o(pwr_off_o),
   .led_o(led_o), .rclk_mode_o(rclk_mode_o),
   .sense_sync(sense_sync), .flag_q(flag_q)
);

// File: tb/sense_ctrl_reg_tb.sv
module sense_ctrl_reg_tb;
   localparam logic [7:0] SET_A = 8'h10;
   localparam logic [7:0] CLR_A = 8'h14;
   localparam logic [31:0] MASK = 32'h13B;

   logic        clk = 0, rst_n = 0;
   logic        wr_en = 0, rd_en = 0;
   logic [7:0]  addr = 0;
   logic [31:0] wdata = 0, rdata;
   logic        rvalid;
   logic        s_rst = 0, s_drop = 0, s_tmo = 0;
   logic        sys_rst, test_rst, pwr_off, rclk_mode;
   logic [1:0]  led;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [31:0] exp_ctrl = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   sense_ctrl_reg u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
      .sense_sysrst_i(s_rst), .sense_pwr_drop_i(s_drop), .sense_rclk_to_i(s_tmo),
      .sys_rst_o(sys_rst), .test_rst_o(test_rst), .pwr_off_o(pwr_off),
      .led_o(led), .rclk_mode_o(rclk_mode)
   );

   // Monitor: compares each read result with the queued expectation.
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s unexpected read data actual=%h expected=none", "R5", rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s read actual=%h expected=%h", t, rdata, e);
            end
         end
      end
   end

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      if (a == SET_A) exp_ctrl = exp_ctrl | (d & MASK);
      if (a == CLR_A) exp_ctrl = exp_ctrl & ~d;
      @(negedge clk);
      wr_en = 0; wdata = 0;
   endtask

   task automatic do_read(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      rd_en = 1; addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic chk_outs(input string t);
      logic [5:0] act, exp;
      act = {rclk_mode, led, pwr_off, test_rst, sys_rst};
      exp = {exp_ctrl[8], exp_ctrl[5], exp_ctrl[4], exp_ctrl[3], exp_ctrl[1], exp_ctrl[0]};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s outputs actual=%b expected=%b", t, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(1);
      chk_outs("R4 reset");
      do_read(SET_A, 32'h0, "R4 reset read");
      // R3 LEDs
      do_write(SET_A, 32'h30);
      chk_outs("R3 leds");
      do_read(SET_A, 32'h30, "R1 set leds");
      do_write(SET_A, 32'h103);
      chk_outs("R3 resets and clock mode");
      do_read(SET_A, 32'h133, "R1 set keeps others");
      do_write(CLR_A, 32'h1);
      chk_outs("R2 clear system reset");
      do_read(CLR_A, 32'h132, "R5 read at clear address");
      do_write(SET_A, 32'h8);
      chk_outs("R3 power off");
      do_write(CLR_A, 32'h8);
      chk_outs("R3 power on");
      do_write(SET_A, 32'hFFFF_FFFF);
      chk_outs("R1 all ones");
      do_read(SET_A, 32'h13B, "R1 unimplemented bits read 0");
      do_write(CLR_A, 32'hFFFF_FFFF);
      chk_outs("R2 clear all");
      // R10 other address
      do_write(8'h18, 32'h13B);
      chk_outs("R10 foreign write");
      do_read(8'h18, 32'h0, "R5 foreign read");
      do_read(SET_A, 32'h0, "R10 foreign write ignored");
      // R6 sticky system reset flag
      s_rst = 1; idle(4);
      do_read(SET_A, 32'h40, "R6 flag set");
      s_rst = 0; idle(4);
      do_read(SET_A, 32'h40, "R6 flag sticky");
      // R7/R11 re-arm with input still high
      s_rst = 1; idle(4);
      do_write(SET_A, 32'h40);
      chk_outs("R10 flag write leaves outputs");
      do_read(SET_A, 32'h40, "R11 event wins over re-arm");
      s_rst = 0; idle(4);
      do_write(SET_A, 32'h40);
      do_read(SET_A, 32'h0, "R7 re-arm clears");
      // R8 power dropout pulse
      s_drop = 1; idle(2); s_drop = 0; idle(4);
      do_read(CLR_A, 32'h80, "R8 pulse latched");
      do_write(CLR_A, 32'h80);
      do_read(CLR_A, 32'h80, "R8 clear address ignored");
      do_write(SET_A, 32'h80);
      do_read(CLR_A, 32'h0, "R8 re-arm clears");
      // R9 timeout flag
      s_tmo = 1; idle(2); s_tmo = 0; idle(4);
      do_read(SET_A, 32'h400, "R9 timeout latched");
      do_write(SET_A, 32'h400);
      do_read(SET_A, 32'h400, "R9 set address ignored");
      do_write(CLR_A, 32'h400);
      do_read(SET_A, 32'h0, "R9 clear address clears");
      // R11 timeout event during clear
      s_tmo = 1; idle(4);
      do_write(CLR_A, 32'h400);
      do_read(SET_A, 32'h400, "R11 timeout event wins");
      s_tmo = 0; idle(4);
      do_write(CLR_A, 32'h400);
      // R5 merged view
      do_write(SET_A, 32'h21);
      s_rst = 1; idle(4); s_rst = 0;
      do_read(CLR_A, 32'h61, "R5 merged control and flags");
      idle(3);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R5 missing read results actual=%0d expected=0", exp_q.size());
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule